// File: doc/BRIEF.md
# Core-Voltage Standby Supervisor

This block watches digitized readings of a processor core supply and decides when the system has dropped into a low-power standby state. When a reading falls under a programmable low limit, the block latches a sticky under-voltage status flag. If alerts are enabled, it also drives a level alert output. While the supply stays under the limit, the block pauses an over-temperature duration timer, which keeps its accumulated count instead of resetting. When a later reading shows the supply has recovered, monitoring resumes and the timer carries on from the count it held.

Software reaches a small register file through a simple write/read port. Through it, software sets the control bits, the low limit and a fan duty value, reads and clears the status flag, and reads the timer one byte at a time. Out of reset, monitoring is off and the duty output sits at full scale, so the fan runs flat out until software programs the block.

Top module: `core_standby_sup`

## Requirements
- R1: After reset, the control register (address 0) reads 0, the limit (address 1) reads 0, status (address 2) reads 0, the timer (addresses 4 and 5) reads 0, `alert_o` is low, and the duty register (address 3) and `pwm_duty_o` are 0xFF.
- R2: With monitoring on (control bit 0 = 1), a sample taken with `vsample_valid` high sets status bit 1 on the following clock edge when the sample is strictly less than the limit, as an unsigned 8-bit comparison.
- R3: A sample equal to or above the limit sets nothing. When `vsample_valid` is low, the value on `vsample` is ignored.
- R4: Status bit 1 is sticky. A read of address 2 returns its current value and then clears it, but only if the most recent valid sample was not under the limit. Otherwise the bit stays set.
- R5: `alert_o` is high exactly when alert enable (control bit 1) is 1 and status bit 1 is set.
- R6: The timer increments by one on each clock edge where `tick` is high, `ot_n` is low, monitoring is on and the latest sample is not under the limit. While under the limit, the timer holds its value. With `ot_n` high, it does not count.
- R7: After the supply recovers, the timer continues counting from the value it held.
- R8: The timer is 16 bits wide and saturates at 0xFFFF.
- R9: With monitoring off, samples change no status and the timer does not count.
- R10: Writes to addresses 2, 4 and 5 have no effect. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| vsample | input | 8 | Core-voltage reading |
| vsample_valid | input | 1 | Reading is valid this cycle |
| ot_n | input | 1 | Active-low over-temperature input |
| tick | input | 1 | Timer time-base tick |
| alert_o | output | 1 | Level alert output |
| pwm_duty_o | output | 8 | Fan duty value |

## Verification
The bench sweeps every 8-bit reading against limits at both ends of the range and at the midpoint. A comparator that used less-or-equal, or a signed comparison, would set status on the wrong side of the limit. Status reads are issued while the supply is still low, to catch a design that clears the flag without checking the condition. The timer is run through entering standby, holding, recovering and saturating: a design that cleared the count instead of pausing it, or that wrapped past 0xFFFF, shows a wrong timer value. Alert gating, a disabled monitor and writes to read-only addresses are each checked at the ports.

// File: rtl/csup_pkg.sv
package csup_pkg;
    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_LIMIT  = 3'd1,
        A_STATUS = 3'd2,
        A_DUTY   = 3'd3,
        A_TMR_LO = 3'd4,
        A_TMR_HI = 3'd5
    } csup_addr_e;

    localparam int CTRL_MON_BIT = 0;
    localparam int CTRL_AEN_BIT = 1;
    localparam int STS_UV_BIT   = 1;
endpackage

// File: rtl/csup_regfile.sv
module csup_regfile
    import csup_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sts_uv,
    input  logic [TMR_W-1:0]  timer,
    output logic              mon_en,
    output logic              alert_en,
    output logic [DATA_W-1:0] limit,
    output logic [DATA_W-1:0] duty,
    output logic              sts_rd
);
    localparam int EXT_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] limit;
        logic [DATA_W-1:0] duty;
    } regs_t;

    regs_t r_d, r_q;
    logic [EXT_W-1:0]  tmr_ext;
    logic [DATA_W-1:0] sts_word;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (addr)
                A_CTRL:  r_d.ctrl  = wdata;
                A_LIMIT: r_d.limit = wdata;
                A_DUTY:  r_d.duty  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl  <= '0;
            r_q.limit <= '0;
            r_q.duty  <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        tmr_ext              = EXT_W'(timer);
        sts_word             = '0;
        sts_word[STS_UV_BIT] = sts_uv;
        unique case (addr)
            A_CTRL:   rdata = r_q.ctrl;
            A_LIMIT:  rdata = r_q.limit;
            A_STATUS: rdata = sts_word;
            A_DUTY:   rdata = r_q.duty;
            A_TMR_LO: rdata = tmr_ext[DATA_W-1:0];
            A_TMR_HI: rdata = tmr_ext[EXT_W-1:DATA_W];
            default:  rdata = '0;
        endcase
    end

    assign mon_en   = r_q.ctrl[CTRL_MON_BIT];
    assign alert_en = r_q.ctrl[CTRL_AEN_BIT];
    assign limit    = r_q.limit;
    assign duty     = r_q.duty;
    assign sts_rd   = rd_en && (addr == A_STATUS);
endmodule

// File: rtl/csup_uv_detect.sv
module csup_uv_detect #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mon_en,
    input  logic [DATA_W-1:0] vsample,
    input  logic              vsample_valid,
    input  logic [DATA_W-1:0] limit,
    input  logic              sts_rd,
    output logic              uv,
    output logic              sts_uv
);
    typedef struct packed {
        logic uv;
        logic sts;
    } uv_t;

    uv_t  s_d, s_q;
    logic take;
    logic below;

    always_comb begin
        s_d   = s_q;
        take  = mon_en && vsample_valid;
        below = vsample < limit;
        if (take) begin
            s_d.uv = below;
        end
        if (take && below) begin
            s_d.sts = 1'b1;
        end else if (sts_rd && !s_q.uv) begin
            s_d.sts = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign uv     = s_q.uv;
    assign sts_uv = s_q.sts;
endmodule

// File: rtl/csup_ot_timer.sv
module csup_ot_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             ot_n,
    output logic [TMR_W-1:0] count
);
    localparam logic [TMR_W-1:0] TMR_MAX = '1;

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (run && tick && !ot_n && (t_q.cnt != TMR_MAX)) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign count = t_q.cnt;
endmodule

// File: rtl/core_standby_sup.sv
module core_standby_sup #(
    parameter int DATA_W = 8,
    parameter int TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [2:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] vsample,
    input  logic              vsample_valid,
    input  logic              ot_n,
    input  logic              tick,
    output logic              alert_o,
    output logic [DATA_W-1:0] pwm_duty_o
);
    logic              mon_en;
    logic              alert_en;
    logic [DATA_W-1:0] limit;
    logic              sts_rd;
    logic              uv_flag;
    logic              sts_uv;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_run;

    csup_regfile #(.DATA_W(DATA_W), .TMR_W(TMR_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .sts_uv   (sts_uv),
        .timer    (tmr_val),
        .mon_en   (mon_en),
        .alert_en (alert_en),
        .limit    (limit),
        .duty     (pwm_duty_o),
        .sts_rd   (sts_rd)
    );

    csup_uv_detect #(.DATA_W(DATA_W)) uv_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mon_en        (mon_en),
        .vsample       (vsample),
        .vsample_valid (vsample_valid),
        .limit         (limit),
        .sts_rd        (sts_rd),
        .uv            (uv_flag),
        .sts_uv        (sts_uv)
    );

    assign tmr_run = mon_en && !uv_flag;

    csup_ot_timer #(.TMR_W(TMR_W)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .tick  (tick),
        .ot_n  (ot_n),
        .count (tmr_val)
    );

    assign alert_o = alert_en && sts_uv;
endmodule

// File: rtl/csup_checker.sv
module csup_checker #(
    parameter int DATA_W = 8,
    parameter int TMR_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mon_en,
    input logic              aen,
    input logic [DATA_W-1:0] vsample,
    input logic              vsample_valid,
    input logic [DATA_W-1:0] limit,
    input logic              uv,
    input logic              sts,
    input logic              sts_rd,
    input logic [TMR_W-1:0]  timer,
    input logic              alert_o
);
    p_set_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && vsample_valid && (vsample < limit)) |=> sts);

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && !sts_rd) |=> sts);

    p_keep_while_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && uv && !(mon_en && vsample_valid)) |=> sts);

    p_alert_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && aen) |-> alert_o);

    p_alert_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sts |-> !alert_o);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uv |=> $stable(timer));

    p_no_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> $stable(timer));

    p_no_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_en && !sts_rd) |=> $stable(sts));

    p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&timer) |=> (&timer));
endmodule

bind core_standby_sup csup_checker #(.DATA_W(DATA_W), .TMR_W(TMR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mon_en        (mon_en),
    .aen           (alert_en),
    .vsample       (vsample),
    .vsample_valid (vsample_valid),
    .limit         (limit),
    .uv            (uv_flag),
    .sts           (sts_uv),
    .sts_rd        (sts_rd),
    .timer         (tmr_val),
    .alert_o       (alert_o)
);

// File: tb/core_standby_sup_tb.sv
module core_standby_sup_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_rd_en = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] vsample = '0;
    logic       vsample_valid = 1'b0;
    logic       ot_n = 1'b1;
    logic       tick = 1'b0;
    logic       alert_o;
    logic [7:0] pwm_duty_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    core_standby_sup dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vsample(vsample), .vsample_valid(vsample_valid), .ot_n(ot_n),
        .tick(tick), .alert_o(alert_o), .pwm_duty_o(pwm_duty_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd_en = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic smp(input logic [7:0] v);
        @(negedge clk);
        vsample = v; vsample_valid = 1'b1;
        @(negedge clk);
        vsample_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd_timer(output int t);
        logic [7:0] lo, hi;
        rd(3'd4, lo);
        rd(3'd5, hi);
        t = {hi, lo};
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int t;
        int lims[6] = '{0, 1, 8'h7F, 8'h80, 8'hFE, 8'hFF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, d); chk("R1 ctrl", d, 0);
        rd(3'd1, d); chk("R1 limit", d, 0);
        rd(3'd2, d); chk("R1 status", d, 0);
        rd(3'd3, d); chk("R1 duty", d, 8'hFF);
        rd_timer(t); chk("R1 timer", t, 0);
        chk("R1 alert", alert_o, 0);
        chk("R1 pwm", pwm_duty_o, 8'hFF);

        // R10 read-only addresses ignore writes
        wr(3'd2, 8'hFF); rd(3'd2, d); chk("R10 status write", d, 0);
        wr(3'd4, 8'h55); wr(3'd5, 8'hAA); rd_timer(t); chk("R10 timer write", t, 0);
        wr(3'd3, 8'h40); chk("R10 duty write", pwm_duty_o, 8'h40);

        // R9 monitoring off: under-limit sample sets nothing
        wr(3'd1, 8'h80);
        smp(8'h00); rd(3'd2, d); chk("R9 status idle", d, 0);

        // R2 R3 sweep over limits and all readings
        wr(3'd0, 8'h01);
        foreach (lims[i]) begin
            wr(3'd1, 8'(lims[i]));
            for (int s = 0; s < 256; s++) begin
                smp(8'hFF);
                rd(3'd2, d);
                smp(8'(s));
                rd(3'd2, d);
                chk((s < lims[i]) ? "R2 below sets" : "R3 not below",
                    d[1], (s < lims[i]) ? 1 : 0);
            end
        end

        // R3 no valid strobe: reading ignored
        wr(3'd1, 8'h80);
        smp(8'hFF); rd(3'd2, d);
        @(negedge clk); vsample = 8'h00;
        repeat (4) @(negedge clk);
        rd(3'd2, d); chk("R3 no strobe", d, 0);

        // R4 sticky, read clears only after recovery
        smp(8'h10);
        rd(3'd2, d); chk("R4 read while low", d, 2);
        rd(3'd2, d); chk("R4 still set", d, 2);
        smp(8'h90);
        rd(3'd2, d); chk("R4 read after recover", d, 2);
        rd(3'd2, d); chk("R4 cleared", d, 0);

        // R5 alert gating
        smp(8'h10);
        chk("R5 alert disabled", alert_o, 0);
        wr(3'd0, 8'h03);
        chk("R5 alert enabled", alert_o, 1);
        smp(8'h90); rd(3'd2, d);
        chk("R5 alert drops", alert_o, 0);

        // R6 R7 timer run, hold, resume
        wr(3'd0, 8'h01);
        @(negedge clk); ot_n = 1'b1;
        ticks(6); rd_timer(t); chk("R6 ot_n high", t, 0);
        @(negedge clk); ot_n = 1'b0;
        ticks(10); rd_timer(t); chk("R6 count", t, 10);
        smp(8'h10);
        ticks(7); rd_timer(t); chk("R6 hold", t, 10);
        smp(8'hC0);
        ticks(5); rd_timer(t); chk("R7 resume", t, 15);
        rd(3'd2, d);

        // R9 monitoring off: no count
        wr(3'd0, 8'h00);
        ticks(3); rd_timer(t); chk("R9 no count", t, 15);
        smp(8'h00); rd(3'd2, d); chk("R9 no status", d, 0);

        // R8 saturation
        wr(3'd0, 8'h01);
        ticks(65530); rd_timer(t); chk("R8 reach max", t, 16'hFFFF);
        ticks(4); rd_timer(t); chk("R8 saturate", t, 16'hFFFF);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule